// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This unit decides where the program counter goes after a control-transfer instruction. While the instruction sits in the execute stage, the unit takes the instruction word, the already incremented PC and the forwarded values of the two source registers. From these it works out the branch target, the zero test on the condition register and the link value. All results pass through one register stage, so they act on the PC while the instruction occupies the memory stage.

Four instruction kinds are handled. Equal and not-equal conditional branches test the ra value against zero. The unconditional branch and the branch-to-subroutine always redirect. The register jump sends the PC to the rb value. The subroutine, unconditional and jump forms also deliver the incremented PC as a link value, to be written into the register named by the ra field. Any other opcode, and any bubble, leaves the PC on its sequential path.

Top module: `brj_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero on the following cycle, even if a branch is being presented.
- R2: Opcode 0x39 (bits 31:26) branches when the ra value is zero. The target is the incremented PC plus the sign-extended 21-bit displacement (bits 20:0) multiplied by four.
- R3: A conditional branch whose condition fails reports not taken, and its next PC equals the incremented PC.
- R4: Opcode 0x3D branches when the ra value is nonzero. It uses the same target arithmetic as R2.
- R5: Opcodes 0x30 and 0x34 always branch to the displacement target. They assert the link write, with the incremented PC as link value and the ra field (bits 25:21) as link destination.
- R6: Opcode 0x1A branches to the rb value with its two low bits cleared, and performs the same link write as R5.
- R7: Negative displacements produce backward targets with correct two's-complement wrap.
- R8: When `ex_valid` is low, the next cycle shows no branch and no link write, whatever the instruction word holds.
- R9: Any other opcode reports not taken and no link write, and its next PC equals the incremented PC.
- R10: A taken equal-branch at address 0 (incremented PC 4) with displacement 5 redirects to 0x18.
- R11: Results appear exactly one clock after the execute-stage inputs that produced them, and each cycle's inputs affect only the next cycle's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_valid | input | 1 | Execute stage holds a real instruction (low means bubble) |
| ex_instr | input | 32 | Instruction word in execute |
| ex_pc_inc | input | AW (32) | Address of the instruction plus four |
| ex_ra_val | input | DW (64) | Forwarded value of the ra source |
| ex_rb_val | input | DW (64) | Forwarded value of the rb source |
| mem_taken | output | 1 | Redirect the PC this cycle |
| mem_target | output | AW (32) | Computed branch or jump target |
| mem_next_pc | output | AW (32) | PC to fetch next: target if taken, else incremented PC |
| mem_link_val | output | DW (64) | Return address to write into the link register |
| mem_link_we | output | 1 | Link register write enable |
| mem_link_dst | output | 5 | Link register index (ra field) |

## Verification
The redirect and the link write fall in the same cycle for the subroutine, unconditional and jump forms. Each vector of these kinds checks the taken flag, the next PC, the link enable, the link value and the destination in one sample. The second coincidence is bubble suppression landing on a cycle that carries an always-taken opcode. It is provoked by an unconditional branch presented with `ex_valid` low, and it is judged by the absence of both redirect and link write. A reset arriving while a branch is in flight is checked the same way.

// File: rtl/brj_pkg.sv
package brj_pkg;
  localparam int INSTR_W = 32;
  localparam int OP_W    = 6;
  localparam int REG_W   = 5;
  localparam int DISP_W  = 21;

  localparam logic [OP_W-1:0] OP_BEQ = 6'h39;
  localparam logic [OP_W-1:0] OP_BNE = 6'h3D;
  localparam logic [OP_W-1:0] OP_BR  = 6'h30;
  localparam logic [OP_W-1:0] OP_BSR = 6'h34;
  localparam logic [OP_W-1:0] OP_JMP = 6'h1A;

  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,
    CLS_EQZ   = 3'd1,
    CLS_NEZ   = 3'd2,
    CLS_ALWAYS = 3'd3,
    CLS_REG   = 3'd4
  } xfer_cls_e;
endpackage

// File: rtl/brj_decode.sv
module brj_decode
  import brj_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output xfer_cls_e          cls,
  output logic               links,
  output logic [REG_W-1:0]   link_reg,
  output logic [DISP_W-1:0]  disp
);
  logic [OP_W-1:0] op;

  assign op       = instr[31:26];
  assign link_reg = instr[25:21];
  assign disp     = instr[DISP_W-1:0];

  always_comb begin
    cls   = CLS_NONE;
    links = 1'b0;
    unique case (op)
      OP_BEQ: cls = CLS_EQZ;
      OP_BNE: cls = CLS_NEZ;
      OP_BR, OP_BSR: begin
        cls   = CLS_ALWAYS;
        links = 1'b1;
      end
      OP_JMP: begin
        cls   = CLS_REG;
        links = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/brj_target.sv
module brj_target
  import brj_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  xfer_cls_e         cls,
  input  logic [AW-1:0]     pc_inc,
  input  logic [DISP_W-1:0] disp,
  input  logic [DW-1:0]     rb_val,
  output logic [AW-1:0]     target
);
  localparam int EXT_W = AW - DISP_W - 2;

  logic [AW-1:0] disp_off;
  logic [AW-1:0] rel_tgt;
  logic [AW-1:0] abs_tgt;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp_off = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
    end else begin : g_trunc
      assign disp_off = AW'({disp, 2'b00});
    end
  endgenerate

  assign rel_tgt = pc_inc + disp_off;
  assign abs_tgt = {rb_val[AW-1:2], 2'b00};
  assign target  = (cls == CLS_REG) ? abs_tgt : rel_tgt;
endmodule

// File: rtl/brj_cond.sv
module brj_cond
  import brj_pkg::*;
#(
  parameter int DW = 64
) (
  input  xfer_cls_e     cls,
  input  logic          valid,
  input  logic [DW-1:0] ra_val,
  output logic          taken
);
  logic is_zero;

  assign is_zero = (ra_val == '0);

  always_comb begin
    unique case (cls)
      CLS_EQZ:            taken = valid & is_zero;
      CLS_NEZ:            taken = valid & ~is_zero;
      CLS_ALWAYS, CLS_REG: taken = valid;
      default:            taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/brj_unit.sv
module brj_unit
  import brj_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ex_valid,
  input  logic [INSTR_W-1:0]   ex_instr,
  input  logic [AW-1:0]        ex_pc_inc,
  input  logic [DW-1:0]        ex_ra_val,
  input  logic [DW-1:0]        ex_rb_val,
  output logic                 mem_taken,
  output logic [AW-1:0]        mem_target,
  output logic [AW-1:0]        mem_next_pc,
  output logic [DW-1:0]        mem_link_val,
  output logic                 mem_link_we,
  output logic [REG_W-1:0]     mem_link_dst
);
  typedef logic [DW-1:0] data_t;

  xfer_cls_e         cls;
  logic              links;
  logic [REG_W-1:0]  link_reg;
  logic [DISP_W-1:0] disp;
  logic [AW-1:0]     tgt;
  logic              take;

  brj_decode u_dec (
    .instr    (ex_instr),
    .cls      (cls),
    .links    (links),
    .link_reg (link_reg),
    .disp     (disp)
  );

  brj_target #(.AW(AW), .DW(DW)) u_tgt (
    .cls    (cls),
    .pc_inc (ex_pc_inc),
    .disp   (disp),
    .rb_val (ex_rb_val),
    .target (tgt)
  );

  brj_cond #(.DW(DW)) u_cond (
    .cls    (cls),
    .valid  (ex_valid),
    .ra_val (ex_ra_val),
    .taken  (take)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_taken    <= 1'b0;
      mem_target   <= '0;
      mem_next_pc  <= '0;
      mem_link_val <= '0;
      mem_link_we  <= 1'b0;
      mem_link_dst <= '0;
    end else begin
      mem_taken    <= take;
      mem_target   <= tgt;
      mem_next_pc  <= take ? tgt : ex_pc_inc;
      mem_link_val <= data_t'(ex_pc_inc);
      mem_link_we  <= ex_valid & links;
      mem_link_dst <= link_reg;
    end
  end
endmodule

// File: rtl/brj_unit_chk.sv
module brj_unit_chk
  import brj_pkg::*;
#(
  parameter int AW = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               ex_valid,
  input logic [INSTR_W-1:0] ex_instr,
  input logic [AW-1:0]      ex_pc_inc,
  input logic               mem_taken,
  input logic [AW-1:0]      mem_target,
  input logic [AW-1:0]      mem_next_pc,
  input logic               mem_link_we
);
  logic seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_taken && !mem_link_we && mem_next_pc == '0));

  p_taken_uses_target_r2: assert property (@(posedge clk) disable iff (rst)
    mem_taken |-> (mem_next_pc == mem_target));

  p_fallthrough_r3: assert property (@(posedge clk) disable iff (rst || !seen)
    !mem_taken |-> (mem_next_pc == $past(ex_pc_inc)));

  p_link_needs_taken_r5: assert property (@(posedge clk) disable iff (rst)
    mem_link_we |-> mem_taken);

  p_jump_aligned_r6: assert property (@(posedge clk) disable iff (rst || !seen)
    $past(ex_valid && ex_instr[31:26] == OP_JMP) |-> (mem_taken && mem_target[1:0] == 2'b00));

  p_bubble_quiet_r8: assert property (@(posedge clk) disable iff (rst || !seen)
    !$past(ex_valid) |-> (!mem_taken && !mem_link_we));

  p_uncond_latency_r11: assert property (@(posedge clk) disable iff (rst || !seen)
    $past(ex_valid && (ex_instr[31:26] == OP_BR || ex_instr[31:26] == OP_BSR)) |-> (mem_taken && mem_link_we));
endmodule

bind brj_unit brj_unit_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ex_valid    (ex_valid),
  .ex_instr    (ex_instr),
  .ex_pc_inc   (ex_pc_inc),
  .mem_taken   (mem_taken),
  .mem_target  (mem_target),
  .mem_next_pc (mem_next_pc),
  .mem_link_we (mem_link_we)
);

// File: tb/tb_brj_unit.sv
module tb_brj_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int NVEC = 10;
  localparam int WATCHDOG = 5000;

  logic          clk = 1'b0;
  logic          rst;
  logic          ex_valid;
  logic [31:0]   ex_instr;
  logic [AW-1:0] ex_pc_inc;
  logic [DW-1:0] ex_ra_val;
  logic [DW-1:0] ex_rb_val;
  logic          mem_taken;
  logic [AW-1:0] mem_target;
  logic [AW-1:0] mem_next_pc;
  logic [DW-1:0] mem_link_val;
  logic          mem_link_we;
  logic [4:0]    mem_link_dst;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brj_unit #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .ex_valid(ex_valid), .ex_instr(ex_instr),
    .ex_pc_inc(ex_pc_inc), .ex_ra_val(ex_ra_val), .ex_rb_val(ex_rb_val),
    .mem_taken(mem_taken), .mem_target(mem_target), .mem_next_pc(mem_next_pc),
    .mem_link_val(mem_link_val), .mem_link_we(mem_link_we), .mem_link_dst(mem_link_dst)
  );

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] ra, input logic [20:0] d);
    return {op, ra, d};
  endfunction

  typedef struct packed {
    logic [31:0]   instr;
    logic          valid;
    logic [AW-1:0] pc;
    logic [DW-1:0] ra;
    logic [DW-1:0] rb;
    logic          tk;
    logic [AW-1:0] nxt;
    logic          we;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{mk(6'h39, 5'd31, 21'd5),        1'b1, 32'h4,   64'd0, 64'd0,          1'b1, 32'h18,       1'b0}, // R10, R2
    '{mk(6'h39, 5'd1,  21'h10),       1'b1, 32'h104, 64'd7, 64'd0,          1'b0, 32'h104,      1'b0}, // R3
    '{mk(6'h3D, 5'd2,  21'd3),        1'b1, 32'h200, 64'd7, 64'd0,          1'b1, 32'h20C,      1'b0}, // R4
    '{mk(6'h3D, 5'd2,  21'd3),        1'b1, 32'h300, 64'd0, 64'd0,          1'b0, 32'h300,      1'b0}, // R4, R3
    '{mk(6'h30, 5'd26, 21'd2),        1'b1, 32'h400, 64'd5, 64'd0,          1'b1, 32'h408,      1'b1}, // R5
    '{mk(6'h34, 5'd26, 21'h1FFFFC),   1'b1, 32'h500, 64'd5, 64'd0,          1'b1, 32'h4F0,      1'b1}, // R5, R7
    '{mk(6'h1A, 5'd9,  21'h030000),   1'b1, 32'h600, 64'd0, 64'h12345677,   1'b1, 32'h12345674, 1'b1}, // R6
    '{mk(6'h39, 5'd3,  21'h1FFFFF),   1'b1, 32'h10,  64'd0, 64'd0,          1'b1, 32'hC,        1'b0}, // R7
    '{mk(6'h10, 5'd4,  21'd8),        1'b1, 32'h700, 64'd0, 64'd0,          1'b0, 32'h700,      1'b0}, // R9
    '{mk(6'h30, 5'd26, 21'd2),        1'b0, 32'h800, 64'd0, 64'd0,          1'b0, 32'h800,      1'b0}  // R8
  };

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] ins, input logic [AW-1:0] pc,
                       input logic [DW-1:0] ra, input logic [DW-1:0] rb);
    @(negedge clk);
    ex_valid = v; ex_instr = ins; ex_pc_inc = pc; ex_ra_val = ra; ex_rb_val = rb;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    ex_valid = 1'b0; ex_instr = '0; ex_pc_inc = '0; ex_ra_val = '0; ex_rb_val = '0;
    // R1: branch offered during reset must not show
    drive(1'b1, mk(6'h30, 5'd26, 21'd2), 32'h40, 64'd0, 64'd0);
    @(posedge clk); @(posedge clk); #1;
    check("R1", "taken in reset", {63'd0, mem_taken}, 64'd0);
    check("R1", "link_we in reset", {63'd0, mem_link_we}, 64'd0);
    check("R1", "next_pc in reset", {32'd0, mem_next_pc}, 64'd0);
    check("R1", "link_val in reset", mem_link_val, 64'd0);

    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].valid, VECS[i].instr, VECS[i].pc, VECS[i].ra, VECS[i].rb);
      @(posedge clk); #1;
      check("R2-vec", $sformatf("v%0d taken", i), {63'd0, mem_taken}, {63'd0, VECS[i].tk});
      check("R3-vec", $sformatf("v%0d next_pc", i), {32'd0, mem_next_pc}, {32'd0, VECS[i].nxt});
      check("R5-vec", $sformatf("v%0d link_we", i), {63'd0, mem_link_we}, {63'd0, VECS[i].we});
      if (VECS[i].tk)
        check("R7-vec", $sformatf("v%0d target", i), {32'd0, mem_target}, {32'd0, VECS[i].nxt});
      if (VECS[i].we) begin
        check("R5", $sformatf("v%0d link_val", i), mem_link_val, {32'd0, VECS[i].pc});
        check("R6", $sformatf("v%0d link_dst", i), {59'd0, mem_link_dst}, {59'd0, VECS[i].instr[25:21]});
      end
    end

    // R11: back-to-back, each cycle reflects only the previous cycle's inputs
    drive(1'b1, mk(6'h34, 5'd26, 21'd1), 32'h900, 64'd0, 64'd0);
    @(posedge clk); #1;
    check("R11", "first taken", {63'd0, mem_taken}, 64'd1);
    check("R11", "first next_pc", {32'd0, mem_next_pc}, 64'h904);
    ex_instr = mk(6'h39, 5'd1, 21'd1); ex_ra_val = 64'd1; ex_pc_inc = 32'hA00;
    @(posedge clk); #1;
    check("R11", "second taken", {63'd0, mem_taken}, 64'd0);
    check("R11", "second link_we", {63'd0, mem_link_we}, 64'd0);
    check("R11", "second next_pc", {32'd0, mem_next_pc}, 64'hA00);

    // R8: jump presented as bubble has no effect
    drive(1'b0, mk(6'h1A, 5'd26, 21'd0), 32'hB00, 64'd0, 64'h5000);
    @(posedge clk); #1;
    check("R8", "bubble jump taken", {63'd0, mem_taken}, 64'd0);
    check("R8", "bubble jump link_we", {63'd0, mem_link_we}, 64'd0);

    // R1: reset arriving with a branch in flight
    drive(1'b1, mk(6'h30, 5'd26, 21'd4), 32'hC00, 64'd0, 64'd0);
    @(posedge clk); #1;
    check("R1", "in-flight before reset", {63'd0, mem_taken}, 64'd1);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R1", "taken after reset", {63'd0, mem_taken}, 64'd0);
    check("R1", "link_we after reset", {63'd0, mem_link_we}, 64'd0);
    @(negedge clk); rst = 1'b0; ex_valid = 1'b0;
    @(posedge clk); #1;

    finish_run();
  end
endmodule